// File: doc/BRIEF.md
# Tiled 16-bit Framebuffer Address Walker

This block walks a rectangle of 16-bit pixels in raster order and produces one byte address per accepted beat for a framebuffer held in memory. A single start pulse captures every job setting at once: the base pointer (in 2048-byte units), the buffer width (in 64-pixel units), the rectangle origin and size, and the addressing mode. The walk then advances along x first and then y, offering each address with a valid flag and the current pixel coordinates, and it waits on the consumer's ready input before moving on.

In tiled mode the memory is split into pages of 64×64 pixels (8192 bytes). Each page holds 4 columns by 8 rows of blocks of 16×8 pixels (256 bytes), and inside a block the 128 halfwords sit in an interleaved order. Both the block order and the halfword order are fixed bit permutations, so no lookup memory is needed. The base pointer need not fall on a page boundary, so a buffer may begin in the middle of a page. In linear mode the same walk produces a plain row-major address with a stride of the buffer width times 64 pixels. A read engine, a rectangle upload engine or a fill engine can use the block to address the framebuffer.

Top module: `tile16_addr_walker`

## Requirements
- R1: After reset, valid_o and done_o are low until a start is accepted.
- R2: A start accepted while idle with a non-empty rectangle gives valid_o high in the next cycle, with pix_x_o/pix_y_o equal to the origin.
- R3: Pixels come out in raster order: x increments from the origin through origin+width−1, then x returns to the origin and y increments. Every pixel of the rectangle appears exactly once, and coordinates wrap modulo 4096.
- R4: While valid_o is high and ready_i is low, addr_o, pix_x_o, pix_y_o and done_o hold their values.
- R5: done_o is high together with the last address and drops after that beat is accepted, so it lasts one cycle when ready_i is high. A start with zero width or zero height raises done_o for exactly one cycle with valid_o low.
- R6: A start that arrives while a walk is in progress has no effect on the walk. No extra address is emitted afterwards.
- R7: In tiled mode the page index is (y/64)·width + (x/64). The page base is base·2048 + page_index·8192, where base may be any value, including one that is not page-aligned. Examples: with width 2, pixel (96,16) gives 11264. With base 3 and width 2, pixel (65,65) gives 30732.
- R8: In tiled mode the block index for block row r=(y%64)/8 and block column c=(x%64)/16 is formed from bits: r[0]→bit0, c[0]→bit1, r[1]→bit2, c[1]→bit3, r[2]→bit4. The block contributes index·256 bytes. Examples: (16,0)→512, (0,8)→256, (63,63)→8190 with base 0 and width 1.
- R9: In tiled mode the halfword index for xb=x%16 and yb=y%8 is formed from bits: xb[3]→bit0, xb[0]→bit1, yb[0]→bit2, xb[1]→bit3, xb[2]→bit4, yb[1]→bit5, yb[2]→bit6. It contributes index·2 bytes. Examples: (1,0)→4 and (8,0)→2.
- R10: In linear mode (tiled_i low at start) the address is base·2048 + (width·64·y + x)·2.
- R11: Every emitted address is even. A full 64×64 tiled page at base 0 reaches every halfword slot in [0, 8192) exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse. Captures all job settings when the block is idle |
| tiled_i | input | 1 | 1 = tiled addressing, 0 = linear addressing |
| base_i | input | 9 | Framebuffer base in 2048-byte units |
| fbw_i | input | 6 | Buffer width in 64-pixel units |
| org_x_i | input | 12 | Rectangle origin x |
| org_y_i | input | 12 | Rectangle origin y |
| size_w_i | input | 13 | Rectangle width in pixels (0 = empty) |
| size_h_i | input | 13 | Rectangle height in pixels (0 = empty) |
| ready_i | input | 1 | Consumer accepts the current address |
| addr_o | output | 32 | Byte address of the current pixel |
| valid_o | output | 1 | addr_o and the coordinates are meaningful |
| pix_x_o | output | 12 | x coordinate of the current pixel |
| pix_y_o | output | 12 | y coordinate of the current pixel |
| done_o | output | 1 | Marks the last address, or pulses alone for an empty rectangle |

## Verification
The bench builds the block with its default parameters: 12-bit coordinates, a 9-bit base, a 6-bit width and the linear path enabled, so both address modes can be reached from one build. With these widths the bench can cover a full 64×64 page, a rectangle that crosses page boundaries horizontally and vertically at a base that is not page-aligned, single-pixel jobs at the reference coordinates, and empty rectangles. Random back-pressure on ready is applied during the multi-page tiled job and the linear job, and an intruding start is injected during the linear walk.

// File: rtl/tile16_pkg.sv
package tile16_pkg;

   // Fixed geometry of a 16-bit tiled surface
   localparam int PAGE_LOG   = 6;   // 64x64 pixel page
   localparam int PAGE_BYTES_LOG = 13;
   localparam int BLKW_LOG   = 4;   // block is 16 pixels wide
   localparam int BLKH_LOG   = 3;   // block is 8 pixels tall
   localparam int BLK_BYTES_LOG = 8;
   localparam int BASE_UNIT_LOG = 11; // base pointer counts 2048 bytes

   typedef enum logic [0:0] {
      WK_IDLE = 1'b0,
      WK_RUN  = 1'b1
   } walk_state_e;

   // Block order inside a page: row bits and column bits interleave
   function automatic logic [4:0] blk_perm(input logic [2:0] brow, input logic [1:0] bcol);
      return {brow[2], bcol[1], brow[1], bcol[0], brow[0]};
   endfunction

   // Halfword order inside a block
   function automatic logic [6:0] hw_perm(input logic [2:0] yb, input logic [3:0] xb);
      return {yb[2], yb[1], xb[2], xb[1], yb[0], xb[0], xb[3]};
   endfunction

endpackage

// File: rtl/tile16_walk_ctrl.sv
module tile16_walk_ctrl
   import tile16_pkg::*;
#(
   parameter int COORD_W = 12,
   parameter int BASE_W  = 9,
   parameter int FBW_W   = 6,
   localparam int SIZE_W = COORD_W + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic               tiled_i,
   input  logic [BASE_W-1:0]  base_i,
   input  logic [FBW_W-1:0]   fbw_i,
   input  logic [COORD_W-1:0] org_x_i,
   input  logic [COORD_W-1:0] org_y_i,
   input  logic [SIZE_W-1:0]  size_w_i,
   input  logic [SIZE_W-1:0]  size_h_i,
   input  logic               ready_i,
   output logic [COORD_W-1:0] cur_x_o,
   output logic [COORD_W-1:0] cur_y_o,
   output logic [BASE_W-1:0]  base_o,
   output logic [FBW_W-1:0]   fbw_o,
   output logic               tiled_o,
   output logic               valid_o,
   output logic               done_o
);

   walk_state_e        state_q;
   logic [COORD_W-1:0] ox_q, oy_q;
   logic [SIZE_W-1:0]  w_q, h_q;
   logic [SIZE_W-1:0]  rx_q, ry_q;
   logic [SIZE_W-1:0]  rx_n, ry_n;
   logic [BASE_W-1:0]  base_q;
   logic [FBW_W-1:0]   fbw_q;
   logic               tiled_q;
   logic               valid_q, done_q;
   logic               row_end, empty_req, single_req, accept;

   assign row_end    = (rx_q == w_q - SIZE_W'(1));
   assign empty_req  = (size_w_i == '0) || (size_h_i == '0);
   assign single_req = (size_w_i == SIZE_W'(1)) && (size_h_i == SIZE_W'(1));
   assign accept     = valid_q && ready_i;

   always_comb begin
      if (row_end) begin
         rx_n = '0;
         ry_n = ry_q + SIZE_W'(1);
      end else begin
         rx_n = rx_q + SIZE_W'(1);
         ry_n = ry_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= WK_IDLE;
         ox_q    <= '0;
         oy_q    <= '0;
         w_q     <= '0;
         h_q     <= '0;
         rx_q    <= '0;
         ry_q    <= '0;
         base_q  <= '0;
         fbw_q   <= '0;
         tiled_q <= 1'b0;
         valid_q <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         case (state_q)
            WK_IDLE: begin
               done_q <= 1'b0;
               if (start_i) begin
                  ox_q    <= org_x_i;
                  oy_q    <= org_y_i;
                  w_q     <= size_w_i;
                  h_q     <= size_h_i;
                  base_q  <= base_i;
                  fbw_q   <= fbw_i;
                  tiled_q <= tiled_i;
                  rx_q    <= '0;
                  ry_q    <= '0;
                  if (empty_req) begin
                     done_q <= 1'b1;
                  end else begin
                     state_q <= WK_RUN;
                     valid_q <= 1'b1;
                     done_q  <= single_req;
                  end
               end
            end
            default: begin
               if (accept) begin
                  if (done_q) begin
                     state_q <= WK_IDLE;
                     valid_q <= 1'b0;
                     done_q  <= 1'b0;
                  end else begin
                     rx_q   <= rx_n;
                     ry_q   <= ry_n;
                     done_q <= (rx_n == w_q - SIZE_W'(1)) && (ry_n == h_q - SIZE_W'(1));
                  end
               end
            end
         endcase
      end
   end

   assign cur_x_o = ox_q + rx_q[COORD_W-1:0];
   assign cur_y_o = oy_q + ry_q[COORD_W-1:0];
   assign base_o  = base_q;
   assign fbw_o   = fbw_q;
   assign tiled_o = tiled_q;
   assign valid_o = valid_q;
   assign done_o  = done_q;

   AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q && !ready_i |=> valid_q && $stable(cur_x_o) && $stable(cur_y_o) && $stable(done_q)); // R4

   AST_DONE_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q && done_q && ready_i |=> !valid_q && !done_q); // R5

   AST_EMPTY_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == WK_IDLE && start_i && empty_req |=> done_q && !valid_q); // R5

   AST_FIRST_AT_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == WK_IDLE && start_i && !empty_req
      |=> valid_q && cur_x_o == $past(org_x_i) && cur_y_o == $past(org_y_i)); // R2

   AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == WK_RUN && start_i && !accept |=> valid_q && $stable(ox_q) && $stable(w_q)); // R6

endmodule

// File: rtl/tile16_tiled_addr.sv
module tile16_tiled_addr
   import tile16_pkg::*;
#(
   parameter int COORD_W = 12,
   parameter int BASE_W  = 9,
   parameter int FBW_W   = 6,
   parameter int ADDR_W  = 32
) (
   input  logic [COORD_W-1:0] x_i,
   input  logic [COORD_W-1:0] y_i,
   input  logic [BASE_W-1:0]  base_i,
   input  logic [FBW_W-1:0]   fbw_i,
   output logic [ADDR_W-1:0]  addr_o
);

   localparam int PG_W  = COORD_W - PAGE_LOG;
   localparam int PIX_W = PG_W + FBW_W + 1;

   logic [PG_W-1:0]   pg_x, pg_y;
   logic [PIX_W-1:0]  page_idx;
   logic [2:0]        brow;
   logic [1:0]        bcol;
   logic [4:0]        blk_idx;
   logic [6:0]        hw_idx;
   logic [ADDR_W-1:0] base_bytes, page_bytes, blk_bytes, hw_bytes;

   assign pg_x = x_i[COORD_W-1:PAGE_LOG];
   assign pg_y = y_i[COORD_W-1:PAGE_LOG];
   assign page_idx = PIX_W'(pg_y) * PIX_W'(fbw_i) + PIX_W'(pg_x);

   assign bcol = x_i[PAGE_LOG-1:BLKW_LOG];
   assign brow = y_i[PAGE_LOG-1:BLKH_LOG];
   assign blk_idx = blk_perm(brow, bcol);
   assign hw_idx  = hw_perm(y_i[BLKH_LOG-1:0], x_i[BLKW_LOG-1:0]);

   assign base_bytes = ADDR_W'(base_i)   << BASE_UNIT_LOG;
   assign page_bytes = ADDR_W'(page_idx) << PAGE_BYTES_LOG;
   assign blk_bytes  = ADDR_W'(blk_idx)  << BLK_BYTES_LOG;
   assign hw_bytes   = ADDR_W'(hw_idx)   << 1;

   assign addr_o = base_bytes + page_bytes + blk_bytes + hw_bytes;

endmodule

// File: rtl/tile16_linear_addr.sv
module tile16_linear_addr
   import tile16_pkg::*;
#(
   parameter int COORD_W = 12,
   parameter int BASE_W  = 9,
   parameter int FBW_W   = 6,
   parameter int ADDR_W  = 32
) (
   input  logic [COORD_W-1:0] x_i,
   input  logic [COORD_W-1:0] y_i,
   input  logic [BASE_W-1:0]  base_i,
   input  logic [FBW_W-1:0]   fbw_i,
   output logic [ADDR_W-1:0]  addr_o
);

   localparam int ROW_W = FBW_W + PAGE_LOG + COORD_W + 1;

   logic [ROW_W-1:0]  stride_pix;
   logic [ROW_W-1:0]  pix_off;

   assign stride_pix = ROW_W'(fbw_i) << PAGE_LOG;
   assign pix_off    = stride_pix * ROW_W'(y_i) + ROW_W'(x_i);
   assign addr_o     = (ADDR_W'(base_i) << BASE_UNIT_LOG) + (ADDR_W'(pix_off) << 1);

endmodule

// File: rtl/tile16_addr_walker.sv
module tile16_addr_walker
   import tile16_pkg::*;
#(
   parameter int COORD_W   = 12,
   parameter int BASE_W    = 9,
   parameter int FBW_W     = 6,
   parameter int ADDR_W    = 32,
   parameter bit LINEAR_EN = 1'b1,
   localparam int SIZE_W   = COORD_W + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic               tiled_i,
   input  logic [BASE_W-1:0]  base_i,
   input  logic [FBW_W-1:0]   fbw_i,
   input  logic [COORD_W-1:0] org_x_i,
   input  logic [COORD_W-1:0] org_y_i,
   input  logic [SIZE_W-1:0]  size_w_i,
   input  logic [SIZE_W-1:0]  size_h_i,
   input  logic               ready_i,
   output logic [ADDR_W-1:0]  addr_o,
   output logic               valid_o,
   output logic [COORD_W-1:0] pix_x_o,
   output logic [COORD_W-1:0] pix_y_o,
   output logic               done_o
);

   // Elaboration checks on the parameter set
   if (COORD_W <= PAGE_LOG) begin : g_bad_coord
      $error("COORD_W must exceed the page size exponent");
   end
   if (ADDR_W < (COORD_W - PAGE_LOG) + FBW_W + 1 + PAGE_BYTES_LOG) begin : g_bad_addr_t
      $error("ADDR_W too narrow for the tiled page range");
   end
   if (ADDR_W < BASE_W + BASE_UNIT_LOG + 1) begin : g_bad_addr_b
      $error("ADDR_W too narrow for the base pointer");
   end
   if (LINEAR_EN && ADDR_W < FBW_W + PAGE_LOG + COORD_W + 2) begin : g_bad_addr_l
      $error("ADDR_W too narrow for the linear range");
   end

   logic [COORD_W-1:0] cur_x, cur_y;
   logic [BASE_W-1:0]  job_base;
   logic [FBW_W-1:0]   job_fbw;
   logic               job_tiled;
   logic [ADDR_W-1:0]  tiled_addr;

   tile16_walk_ctrl #(
      .COORD_W (COORD_W),
      .BASE_W  (BASE_W),
      .FBW_W   (FBW_W)
   ) walk_u (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .tiled_i  (tiled_i),
      .base_i   (base_i),
      .fbw_i    (fbw_i),
      .org_x_i  (org_x_i),
      .org_y_i  (org_y_i),
      .size_w_i (size_w_i),
      .size_h_i (size_h_i),
      .ready_i  (ready_i),
      .cur_x_o  (cur_x),
      .cur_y_o  (cur_y),
      .base_o   (job_base),
      .fbw_o    (job_fbw),
      .tiled_o  (job_tiled),
      .valid_o  (valid_o),
      .done_o   (done_o)
   );

   tile16_tiled_addr #(
      .COORD_W (COORD_W),
      .BASE_W  (BASE_W),
      .FBW_W   (FBW_W),
      .ADDR_W  (ADDR_W)
   ) tiled_u (
      .x_i    (cur_x),
      .y_i    (cur_y),
      .base_i (job_base),
      .fbw_i  (job_fbw),
      .addr_o (tiled_addr)
   );

   if (LINEAR_EN) begin : g_linear
      logic [ADDR_W-1:0] linear_addr;

      tile16_linear_addr #(
         .COORD_W (COORD_W),
         .BASE_W  (BASE_W),
         .FBW_W   (FBW_W),
         .ADDR_W  (ADDR_W)
      ) linear_u (
         .x_i    (cur_x),
         .y_i    (cur_y),
         .base_i (job_base),
         .fbw_i  (job_fbw),
         .addr_o (linear_addr)
      );

      assign addr_o = job_tiled ? tiled_addr : linear_addr;
   end else begin : g_tiled_only
      assign addr_o = tiled_addr;
   end

   assign pix_x_o = cur_x;
   assign pix_y_o = cur_y;

   AST_EVEN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> !addr_o[0]); // R11

   AST_RASTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o && ready_i && !done_o
      |=> valid_o && (pix_x_o == $past(pix_x_o) + COORD_W'(1) || pix_y_o == $past(pix_y_o) + COORD_W'(1))); // R3

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_o && !start_i |=> !valid_o); // R1

endmodule

// File: tb/tile16_addr_walker_tb_top.sv
`timescale 1ns/1ps
module tile16_addr_walker_tb_top;

   typedef struct {
      int     x;
      int     y;
      longint a;
      bit     last;
      bit     tiled;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        tiled_i = 1'b0;
   logic [8:0]  base_i = '0;
   logic [5:0]  fbw_i = '0;
   logic [11:0] org_x_i = '0, org_y_i = '0;
   logic [12:0] size_w_i = '0, size_h_i = '0;
   logic        ready_i = 1'b1;
   logic [31:0] addr_o;
   logic        valid_o, done_o;
   logic [11:0] pix_x_o, pix_y_o;

   always #5 clk = ~clk;

   tile16_addr_walker dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .tiled_i(tiled_i),
      .base_i(base_i), .fbw_i(fbw_i), .org_x_i(org_x_i), .org_y_i(org_y_i),
      .size_w_i(size_w_i), .size_h_i(size_h_i), .ready_i(ready_i),
      .addr_o(addr_o), .valid_o(valid_o), .pix_x_o(pix_x_o), .pix_y_o(pix_y_o),
      .done_o(done_o)
   );

   int   n_checks = 0;
   int   n_fail = 0;
   exp_t q[$];
   bit   mon_en = 1'b0;
   bit   stall_mode = 1'b0;
   bit   empty_pend = 1'b0;
   bit   collect = 1'b0;
   int   seen [0:4095];
   int   cyc = 0;
   bit   prev_stall = 1'b0;
   logic [31:0] prev_addr;
   logic [11:0] prev_x, prev_y;

   // Reference tables written from the stated layout
   int blk_tab [0:31] = '{0,2,8,10, 1,3,9,11, 4,6,12,14, 5,7,13,15,
                          16,18,24,26, 17,19,25,27, 20,22,28,30, 21,23,29,31};
   int row0 [0:15] = '{0,2,8,10,16,18,24,26,1,3,9,11,17,19,25,27};

   function automatic longint ref_addr(int b, int w, int x, int y, bit t);
      int pg, bt, hw, yb;
      if (!t) return longint'(b) * 2048 + (longint'(w) * 64 * y + x) * 2;
      pg = (y / 64) * w + (x / 64);
      bt = blk_tab[((y % 64) / 8) * 4 + (x % 64) / 16];
      yb = y % 8;
      hw = row0[x % 16] + (yb % 2) * 4 + (yb / 2) * 32;
      return longint'(b) * 2048 + longint'(pg) * 8192 + bt * 256 + hw * 2;
   endfunction

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   // Monitor: compares outputs with the reference queue on every clock
   always @(negedge clk) begin
      if (mon_en) begin
         cyc++;
         if (cyc > 150000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            finish_run();
         end
         ready_i = stall_mode ? (($urandom % 3) != 0) : 1'b1;
         if (prev_stall) begin
            chk(valid_o && addr_o == prev_addr && pix_x_o == prev_x && pix_y_o == prev_y,
                "R4 hold", longint'(addr_o), longint'(prev_addr));
         end
         if (valid_o) begin
            if (q.size() == 0) begin
               chk(1'b0, "R6 unexpected beat", longint'(addr_o), -1);
            end else begin
               chk(pix_x_o == 12'(q[0].x) && pix_y_o == 12'(q[0].y), "R3 coord",
                   longint'({pix_y_o, pix_x_o}), longint'(q[0].y * 4096 + q[0].x));
               chk(longint'(addr_o) == q[0].a, q[0].tiled ? "R9 tiled addr" : "R10 linear addr",
                   longint'(addr_o), q[0].a);
               chk(done_o == q[0].last, "R5 done with last", longint'(done_o), longint'(q[0].last));
               if (ready_i) begin
                  if (collect) seen[addr_o[12:1]]++;
                  void'(q.pop_front());
               end
            end
         end else begin
            chk(done_o == empty_pend, "R5 done without beat", longint'(done_o), longint'(empty_pend));
            empty_pend = 1'b0;
         end
         prev_stall = valid_o && !ready_i;
         prev_addr = addr_o;
         prev_x = pix_x_o;
         prev_y = pix_y_o;
      end
   end

   task automatic run_job(input int b, input int w, input int ox, input int oy,
                          input int sw, input int sh, input bit t, input bit stall,
                          input bit intrude);
      stall_mode = stall;
      for (int j = 0; j < sh; j++) begin
         for (int i = 0; i < sw; i++) begin
            exp_t e;
            e.x = (ox + i) % 4096;
            e.y = (oy + j) % 4096;
            e.a = ref_addr(b, w, e.x, e.y, t);
            e.last = (i == sw - 1) && (j == sh - 1);
            e.tiled = t;
            q.push_back(e);
         end
      end
      base_i = 9'(b); fbw_i = 6'(w); org_x_i = 12'(ox); org_y_i = 12'(oy);
      size_w_i = 13'(sw); size_h_i = 13'(sh); tiled_i = t;
      start_i = 1'b1;
      @(posedge clk); #1;
      start_i = 1'b0;
      if (sw == 0 || sh == 0) begin
         empty_pend = 1'b1;
         chk(!valid_o, "R5 empty no valid", longint'(valid_o), 0);
      end else begin
         chk(valid_o && pix_x_o == 12'(ox) && pix_y_o == 12'(oy), "R2 first beat latency",
             longint'({valid_o, pix_y_o, pix_x_o}), longint'(1 << 24 | oy * 4096 + ox));
      end
      if (intrude) begin
         repeat (4) @(posedge clk);
         #1;
         base_i = 9'd7; org_x_i = 12'd200; size_w_i = 13'd0; tiled_i = ~t;
         start_i = 1'b1;
         @(posedge clk); #1;
         start_i = 1'b0;
      end
      while (q.size() != 0) @(posedge clk);
      repeat (3) @(posedge clk);
      #1;
   endtask

   // Single-pixel job with a literal expected address
   task automatic point(input int b, input int w, input int x, input int y,
                        input longint exp, input string req);
      run_job(b, w, x, y, 1, 1, 1'b1, 1'b0, 1'b0);
      chk(ref_addr(b, w, x, y, 1'b1) == exp, req, ref_addr(b, w, x, y, 1'b1), exp);
   endtask

   initial begin
      for (int i = 0; i < 4096; i++) seen[i] = 0;
      repeat (3) @(posedge clk);
      #1;
      chk(!valid_o && !done_o, "R1 reset state", longint'({valid_o, done_o}), 0);
      rst_n = 1'b1;
      @(posedge clk); #1;
      chk(!valid_o && !done_o, "R1 idle after reset", longint'({valid_o, done_o}), 0);
      mon_en = 1'b1;

      // Reference points (literal values, checked through the queue too)
      point(0, 1, 1, 0, 4, "R9 point (1,0)");
      point(0, 1, 8, 0, 2, "R9 point (8,0)");
      point(0, 1, 16, 0, 512, "R8 point (16,0)");
      point(0, 1, 0, 8, 256, "R8 point (0,8)");
      point(0, 1, 63, 63, 8190, "R8 point (63,63)");
      point(0, 2, 96, 16, 11264, "R7 point (96,16)");
      point(3, 2, 65, 65, 30732, "R7 point (65,65)");

      // One block, every halfword position
      run_job(0, 1, 0, 0, 16, 8, 1'b1, 1'b0, 1'b0);

      // Full page, bijection
      collect = 1'b1;
      run_job(0, 1, 0, 0, 64, 64, 1'b1, 1'b0, 1'b0);
      collect = 1'b0;
      for (int i = 0; i < 4096; i++) begin
         chk(seen[i] == 1, "R11 page slot hit once", seen[i], 1);
      end

      // Page-crossing rectangle at a mid-page base under back-pressure
      run_job(3, 2, 60, 60, 10, 7, 1'b1, 1'b1, 1'b0);
      run_job(1, 3, 120, 2, 20, 3, 1'b1, 1'b1, 1'b0);

      // Linear mode, with an intruding start while busy
      run_job(1, 2, 5, 3, 9, 4, 1'b0, 1'b1, 1'b1);
      run_job(0, 1, 4094, 0, 4, 2, 1'b0, 1'b0, 1'b0);

      // Empty rectangles
      run_job(0, 1, 0, 0, 0, 5, 1'b1, 1'b0, 1'b0);
      run_job(0, 1, 0, 0, 7, 0, 1'b0, 1'b0, 1'b0);

      // Tiled intrusion too
      run_job(2, 1, 10, 10, 12, 5, 1'b1, 1'b1, 1'b1);

      mon_en = 1'b0;
      finish_run();
   end

endmodule